// File: doc/BRIEF.md
# Saturating Arithmetic Unit

A 32-bit arithmetic unit that computes one of a family of clamped operations in the same cycle as its inputs and keeps one registered sticky flag that records whether any operation has overflowed. An operation code picks the function. The choices are signed add and subtract with clamping, a signed add that wraps but still records overflow, unsigned add and subtract with clamping, a signed doubling, and clamping to a programmable bit position. The position clamp can act on the whole word or on its two 16-bit halves independently.

The result is purely combinational from the operand, operation and position inputs. The flag rises on the clock edge after any cycle in which the selected operation clamped or overflowed. It stays high until a synchronous clear or reset. The operations themselves never lower it. A pipeline stage that needs saturating arithmetic places the unit between its operand registers and its result register, and it reads or clears the flag as it needs to.

Top module: `sat_alu`

## Requirements
- R1: Operation code 0 is signed add. When both operands have the same sign and the sum's sign differs, the result is 0x7FFFFFFF if operand A is non-negative and 0x80000000 otherwise. In every other case the result is the wrapped sum.
- R2: Operation code 1 is signed subtract (A minus B). When the operands differ in sign and the difference's sign differs from A, the result clamps exactly as in R1. In every other case the result is the wrapped difference.
- R3: Operation code 2 returns the wrapped sum A plus B and never clamps. It counts as a saturation event when the R1 overflow condition holds.
- R4: Operation code 3 is unsigned add, which gives 0xFFFFFFFF when the 32-bit sum carries out. Operation code 4 is unsigned subtract, which gives 0 when B is greater than A. Otherwise each gives the wrapped value.
- R5: Operation code 5 doubles A, treated as signed. The result is 0x7FFFFFFF when A is at least 0x40000000, and 0x80000000 when A is at most 0xC0000000 as a signed value. Both of these cases, including A equal to 0xC0000000, are saturation events. Otherwise the result is A shifted left by one.
- R6: Operation code 6 clamps signed A to position p, the 5-bit pos_i input. The output range is -(2^p) to 2^p-1. Values above the range give 2^p-1, values below it give the bitwise inverse of 2^p-1, and both are saturation events. Values inside the range pass unchanged.
- R7: Operation code 7 clamps A to position p as an unsigned range, 0 to 2^p-1. Negative A (bit 31 set) gives 0, values above 2^p-1 give 2^p-1, and both are saturation events. Other values pass unchanged.
- R8: Operation codes 8 and 9 apply R6 and R7 respectively to each 16-bit half of A. Each half is sign-extended before it is clamped and truncated to 16 bits after it is clamped. Bits 15:0 of the result come from A[15:0] and bits 31:16 come from A[31:16]. A clamp in either half is a saturation event.
- R9: sat_o is 0 after reset. It becomes 1 at the clock edge that ends a cycle with a saturation event, and it then holds 1 through any number of operations while clr_i is low.
- R10: When clr_i is high at a clock edge, sat_o becomes 0 unless the same cycle has a saturation event, in which case sat_o is 1.
- R11: Operation codes 10 to 15 give a result of 0 and are never saturation events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (add and subtract codes only) |
| pos_i | input | 5 | Clamp bit position for codes 6 to 9 |
| clr_i | input | 1 | Synchronous clear of the sticky flag |
| result_o | output | 32 | Combinational result |
| sat_o | output | 1 | Registered sticky saturation flag |

## Verification
The assertions assume that op_i, a_i, b_i and pos_i hold steady from the falling edge until after the rising edge. They also assume these inputs carry known values whenever reset is low, because the range properties for the clamp codes read result_o against pos_i in that same cycle. The bench changes every input only on a falling clock edge and drives every input to zero while reset is high. It uses only positions from 0 to 31, so the signed and unsigned clamp properties never see a position outside the range the unit defines.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int POS_W  = $clog2(DATA_W);
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SADD   = 4'd0,
        OP_SSUB   = 4'd1,
        OP_SADDF  = 4'd2,
        OP_UADD   = 4'd3,
        OP_USUB   = 4'd4,
        OP_SDBL   = 4'd5,
        OP_SSAT   = 4'd6,
        OP_USAT   = 4'd7,
        OP_SSAT16 = 4'd8,
        OP_USAT16 = 4'd9
    } sat_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              hit;
    } sat_res_t;

    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic logic [DATA_W-1:0] signed_clamp(input logic a_sign);
        return a_sign ? MIN_NEG : MAX_POS;
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_pkg::*;
(
    input  sat_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output sat_res_t          res_o
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] QUARTER     = {2'b01, {(DATA_W-2){1'b0}}};
    localparam logic [DATA_W-1:0] NEG_QUARTER = {2'b11, {(DATA_W-2){1'b0}}};

    logic [DATA_W-1:0] sum, dif;
    logic [DATA_W:0]   usum;
    logic              add_ovf, sub_ovf;

    always_comb begin
        sum     = a_i + b_i;
        dif     = a_i - b_i;
        usum    = {1'b0, a_i} + {1'b0, b_i};
        add_ovf = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
        sub_ovf = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != a_i[MSB]);
        res_o   = '0;
        case (op_i)
            OP_SADD: begin
                res_o.hit   = add_ovf;
                res_o.value = add_ovf ? signed_clamp(a_i[MSB]) : sum;
            end
            OP_SSUB: begin
                res_o.hit   = sub_ovf;
                res_o.value = sub_ovf ? signed_clamp(a_i[MSB]) : dif;
            end
            OP_SADDF: begin
                res_o.hit   = add_ovf;
                res_o.value = sum;
            end
            OP_UADD: begin
                res_o.hit   = usum[DATA_W];
                res_o.value = usum[DATA_W] ? '1 : usum[DATA_W-1:0];
            end
            OP_USUB: begin
                res_o.hit   = b_i > a_i;
                res_o.value = (b_i > a_i) ? '0 : dif;
            end
            OP_SDBL: begin
                if ($signed(a_i) >= $signed(QUARTER)) begin
                    res_o.hit   = 1'b1;
                    res_o.value = MAX_POS;
                end else if ($signed(a_i) <= $signed(NEG_QUARTER)) begin
                    res_o.hit   = 1'b1;
                    res_o.value = MIN_NEG;
                end else begin
                    res_o.value = {a_i[DATA_W-2:0], 1'b0};
                end
            end
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_pkg::*;
#(
    parameter int OUT_W = DATA_W
)(
    input  logic [DATA_W-1:0] val_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              sgn_i,
    output logic [OUT_W-1:0]  val_o,
    output logic              hit_o
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] top;
    logic              above, below;

    always_comb begin
        mask  = (ONE << pos_i) - ONE;
        top   = $signed(val_i) >>> pos_i;
        above = !top[MSB] && (top != '0);
        below = top[MSB] && (top != '1);
        hit_o = 1'b0;
        val_o = val_i[OUT_W-1:0];
        if (sgn_i) begin
            if (above) begin
                hit_o = 1'b1;
                val_o = mask[OUT_W-1:0];
            end else if (below) begin
                hit_o = 1'b1;
                val_o = ~mask[OUT_W-1:0];
            end
        end else begin
            if (val_i[MSB]) begin
                hit_o = 1'b1;
                val_o = '0;
            end else if (val_i > mask) begin
                hit_o = 1'b1;
                val_o = mask[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sat_flag.sv
module sat_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R9: flag holds without a clear
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
    // R10: set beats clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    // R10: clear alone lowers the flag
    a_r10_clear_only: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] result_o,
    output logic              sat_o
);
    localparam int LANES = DATA_W / HALF_W;

    sat_op_e           op;
    sat_res_t          arith;
    logic [DATA_W-1:0] word_val;
    logic              word_hit;
    logic [HALF_W-1:0] half_val [LANES];
    logic [LANES-1:0]  half_hit;
    logic [DATA_W-1:0] half_cat;
    logic              hit;

    assign op = sat_op_e'(op_i);

    sat_addsub u_addsub (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (arith)
    );

    sat_clamp #(.OUT_W(DATA_W)) u_word (
        .val_i (a_i),
        .pos_i (pos_i),
        .sgn_i (op == OP_SSAT),
        .val_o (word_val),
        .hit_o (word_hit)
    );

    for (genvar lane = 0; lane < LANES; lane++) begin : g_half
        sat_clamp #(.OUT_W(HALF_W)) u_half (
            .val_i ({{(DATA_W-HALF_W){a_i[lane*HALF_W+HALF_W-1]}},
                     a_i[lane*HALF_W +: HALF_W]}),
            .pos_i (pos_i),
            .sgn_i (op == OP_SSAT16),
            .val_o (half_val[lane]),
            .hit_o (half_hit[lane])
        );
        assign half_cat[lane*HALF_W +: HALF_W] = half_val[lane];
    end

    always_comb begin
        case (op)
            OP_SADD, OP_SSUB, OP_SADDF, OP_UADD, OP_USUB, OP_SDBL: begin
                result_o = arith.value;
                hit      = arith.hit;
            end
            OP_SSAT, OP_USAT: begin
                result_o = word_val;
                hit      = word_hit;
            end
            OP_SSAT16, OP_USAT16: begin
                result_o = half_cat;
                hit      = |half_hit;
            end
            default: begin
                result_o = '0;
                hit      = 1'b0;
            end
        endcase
    end

    sat_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (hit),
        .clr_i  (clr_i),
        .flag_o (sat_o)
    );

    // R1: a clamped signed add lands on one of the two extremes
    a_r1_clamp_extreme: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SADD && hit) |-> (result_o == MAX_POS || result_o == MIN_NEG));
    // R4: unsigned add never returns less than A
    a_r4_uadd_floor: assert property (@(posedge clk) disable iff (rst)
        (op == OP_UADD) |-> (result_o >= a_i));
    // R6: signed clamp output fits p bits plus sign
    a_r6_ssat_range: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SSAT) |-> (($signed(result_o) >>> pos_i) == 0 ||
                             ($signed(result_o) >>> pos_i) == -1));
    // R7: unsigned clamp output has nothing at or above bit p
    a_r7_usat_range: assert property (@(posedge clk) disable iff (rst)
        (op == OP_USAT) |-> ((result_o >> pos_i) == '0));
    // R11: unused codes give zero and leave a low flag low
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (op_i > 4'd9) |-> (result_o == '0));
    a_r11_unused_noflag: assert property (@(posedge clk) disable iff (rst)
        (op_i > 4'd9 && !sat_o) |=> !sat_o);

endmodule

// File: tb/test_sat_alu.sv
module test_sat_alu;

    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i;
    logic [31:0] a_i, b_i;
    logic [4:0]  pos_i;
    logic        clr_i;
    logic [31:0] result_o;
    logic        sat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mflag  = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        flag;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    sat_alu i_sat_alu (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .pos_i    (pos_i),
        .clr_i    (clr_i),
        .result_o (result_o),
        .sat_o    (sat_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void clamp_lane(input longint v, input int pos, input bit sgn,
                                       output longint r, output bit h);
        longint hi, lo;
        hi = (longint'(1) << pos) - 1;
        lo = sgn ? -(longint'(1) << pos) : 0;
        h  = 1'b0;
        r  = v;
        if (v > hi) begin r = hi; h = 1'b1; end
        else if (v < lo) begin r = lo; h = 1'b1; end
    endfunction

    function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                  input int pos, output logic [31:0] r, output bit h);
        longint sa, sb_, ua, ub, t, r0, r1;
        bit h0, h1;
        sa = longint'($signed(a));
        sb_ = longint'($signed(b));
        ua = {32'd0, a};
        ub = {32'd0, b};
        r = '0;
        h = 1'b0;
        case (op)
            4'd0, 4'd1: begin
                t = (op == 4'd0) ? sa + sb_ : sa - sb_;
                if (t > 64'sd2147483647) begin r = 32'h7FFFFFFF; h = 1'b1; end
                else if (t < -64'sd2147483648) begin r = 32'h80000000; h = 1'b1; end
                else r = t[31:0];
            end
            4'd2: begin
                t = sa + sb_;
                r = a + b;
                h = (t > 64'sd2147483647) || (t < -64'sd2147483648);
            end
            4'd3: begin
                t = ua + ub;
                if (t > 64'hFFFFFFFF) begin r = 32'hFFFFFFFF; h = 1'b1; end
                else r = t[31:0];
            end
            4'd4: begin
                if (ub > ua) begin r = '0; h = 1'b1; end
                else r = a - b;
            end
            4'd5: begin
                if (sa >= 64'sd1073741824) begin r = 32'h7FFFFFFF; h = 1'b1; end
                else if (sa <= -64'sd1073741824) begin r = 32'h80000000; h = 1'b1; end
                else begin t = sa * 2; r = t[31:0]; end
            end
            4'd6, 4'd7: begin
                clamp_lane(sa, pos, op == 4'd6, r0, h);
                r = r0[31:0];
            end
            4'd8, 4'd9: begin
                clamp_lane(longint'($signed(a[15:0])), pos, op == 4'd8, r0, h0);
                clamp_lane(longint'($signed(a[31:16])), pos, op == 4'd8, r1, h1);
                r = {r1[15:0], r0[15:0]};
                h = h0 | h1;
            end
            default: begin r = '0; h = 1'b0; end
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input int pos, input bit clr, input string tag);
        exp_t e;
        logic [31:0] r;
        bit h;
        @(negedge clk);
        op_i  = op;
        a_i   = a;
        b_i   = b;
        pos_i = 5'(pos);
        clr_i = clr;
        model(op, a, b, pos, r, h);
        mflag = h | (mflag & ~clr);
        e.res  = r;
        e.flag = mflag;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " result"}, result_o, e.res);
            chk({e.tag, " flag"}, {31'd0, sat_o}, {31'd0, e.flag});
        end
    end

    initial begin
        rst = 1'b1; op_i = '0; a_i = '0; b_i = '0; pos_i = '0; clr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk("R9 reset flag", {31'd0, sat_o}, 32'd0);

        apply(4'd0, 32'h7FFFFFFF, 32'h00000001, 0, 1, "R1 add pos clamp");
        apply(4'd0, 32'h80000000, 32'hFFFFFFFF, 0, 1, "R1 add neg clamp");
        apply(4'd0, 32'd5, 32'd7, 0, 1, "R1 add plain");
        apply(4'd1, 32'h80000000, 32'd1, 0, 1, "R2 sub neg clamp");
        apply(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1, "R2 sub pos clamp");
        apply(4'd1, 32'd10, 32'd3, 0, 1, "R2 sub plain");
        apply(4'd2, 32'h7FFFFFFF, 32'd1, 0, 1, "R3 flag-only add");
        apply(4'd2, 32'd100, 32'hFFFFFFFF, 0, 1, "R3 flag-only add plain");
        apply(4'd3, 32'hFFFFFFF0, 32'h20, 0, 1, "R4 uadd clamp");
        apply(4'd3, 32'h1000, 32'h20, 0, 1, "R4 uadd plain");
        apply(4'd4, 32'd3, 32'd5, 0, 1, "R4 usub clamp");
        apply(4'd4, 32'd5, 32'd3, 0, 1, "R4 usub plain");
        apply(4'd5, 32'h40000000, 0, 0, 1, "R5 dbl upper");
        apply(4'd5, 32'hC0000000, 0, 0, 1, "R5 dbl lower edge");
        apply(4'd5, 32'hC0000001, 0, 0, 1, "R5 dbl inside neg");
        apply(4'd5, 32'h3FFFFFFF, 0, 0, 1, "R5 dbl inside pos");
        apply(4'd6, 32'd200, 0, 7, 1, "R6 ssat above");
        apply(4'd6, -32'sd300, 0, 7, 1, "R6 ssat below");
        apply(4'd6, -32'sd128, 0, 7, 1, "R6 ssat edge");
        apply(4'd6, 32'hFFFFFFFF, 0, 0, 1, "R6 ssat pos0 pass");
        apply(4'd6, 32'd5, 0, 0, 1, "R6 ssat pos0 clamp");
        apply(4'd7, -32'sd5, 0, 8, 1, "R7 usat neg");
        apply(4'd7, 32'd300, 0, 8, 1, "R7 usat above");
        apply(4'd7, 32'd255, 0, 8, 1, "R7 usat edge");
        apply(4'd7, 32'h7FFFFFFF, 0, 31, 1, "R7 usat pos31");
        apply(4'd8, 32'hFF000100, 0, 7, 1, "R8 ssat16 both halves");
        apply(4'd8, 32'h0012FFF0, 0, 7, 1, "R8 ssat16 none");
        apply(4'd9, 32'h80000123, 0, 8, 1, "R8 usat16 both halves");
        apply(4'd9, 32'h00FF0100, 0, 8, 1, "R8 usat16 low only");
        apply(4'd0, 32'h7FFFFFFF, 32'd9, 0, 1, "R9 set");
        apply(4'd0, 32'd1, 32'd1, 0, 0, "R9 hold 1");
        apply(4'd7, 32'd3, 0, 4, 0, "R9 hold 2");
        apply(4'd0, 32'h7FFFFFFF, 32'd9, 0, 1, "R10 set beats clear");
        apply(4'd0, 32'd1, 32'd1, 0, 1, "R10 clear");
        apply(4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 31, 0, "R11 code 12");
        apply(4'd15, 32'h80000000, 32'h1, 3, 0, "R11 code 15");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule